// File: doc/BRIEF.md
# Equalizer Mode and Mute Arbiter

This block is the control core of an adaptive cable equalizer. It takes the board-level strap pins and the register fields loaded by a serial configuration port, picks one of the two sets with a mode-select input, and turns the result into power, bypass, mute and driver-enable controls. The analog front end supplies three measured inputs: a signal-detect flag, a 9-bit cable-length index (CLI) and a 2-bit detected-rate code.

In software mode, the block compares the cable-length index with a limit picked by a 5-bit code. A cable longer than the limit mutes the outputs and raises the signal-detect-complement output. A fixed precedence decides the final controls when several requests are active at once: sleep wins over mute, and mute wins over any bypass. The jitter cleaner runs only for the two high rates, and only when nothing bypasses it.

Top module: `eq_mode_mute_ctrl`

## Requirements
- R1: With `sw_mode_i` = 0 only the hardware pins (`hw_bypass_i`, `hw_autosleep_i`, `hw_mute_i`) control operation and every `reg_*` input is ignored. With `sw_mode_i` = 1 only the `reg_*` fields control operation and those three pins are ignored. `hw_drv1_off_i` acts in both modes.
- R2: In hardware mode, `hw_bypass_i` encodes the pin level: 00 = low, 01 = floating, 10 or 11 = high. Low gives normal operation. Floating bypasses only the jitter cleaner (`jc_en_o` = 0, `eq_bypass_o` = 0). High bypasses both the equalizer and the jitter cleaner (`eq_bypass_o` = 1, `jc_en_o` = 0). In software mode, `reg_eq_byp_i` bypasses the equalizer and `reg_jc_byp_i` bypasses the jitter cleaner, each on its own.
- R3: In hardware mode, with `hw_autosleep_i` = 1 the block powers down (`eq_en_o` = 0) while `sig_det_i` = 0. With `hw_autosleep_i` = 0 the equalizer stays enabled.
- R4: The software sleep field `reg_sleep_i` is decoded as follows: 00 = always enabled, 01 = power down while no signal is detected, 10 = forced power down, 11 = reserved and treated as 00.
- R5: Sleep takes precedence over mute, and mute over bypass. Asleep: `eq_en_o`, `eq_bypass_o`, `jc_en_o`, `mute_o` and both driver enables are 0. Muted: `mute_o` = 1, `eq_en_o` = 1, `eq_bypass_o` = 0, `jc_en_o` = 0.
- R6: `sd_n_o` is 1 when `sig_det_i` = 0 or when the registered threshold comparison is over its limit, and 0 otherwise.
- R7: The threshold code maps to a limit in metres: 0→10, 2→25, 5→50, 7→75, 10→100, 12→125, 15→150, 17→175, 20→200, 25→250, 26→300, 27→350, 28→400, 30→450, 31→never. A code not in this list uses the next higher listed code. The limit is converted to a CLI value with CLI = m/0.625 up to 250 m and CLI = 400 + (m−250)/2.5 above 250 m. The cable is over its limit when CLI is strictly greater than that value.
- R8: The comparison result is stored in a register at each clock edge. It is set only when `sw_mode_i` = 1, `reg_dmute_en_i` = 1 and `sig_det_i` = 1, and it is cleared otherwise. When set, it mutes the outputs (R5) and raises `sd_n_o` from the next cycle on. With `reg_dmute_en_i` = 0, the cable length has no effect.
- R9: `jc_en_o` is 1 only when the block is neither asleep nor muted, nothing bypasses the jitter cleaner, and `rate_i` is 01 (HD) or 10 (3G). Code 00 (SD) and code 11 (rate undetermined) keep the jitter cleaner off.
- R10: Each output driver is enabled only while the block is awake. In software mode a swing code of 00 disables the corresponding driver. In hardware mode both drivers are on and the swing fields are ignored. `hw_drv1_off_i` = 1 forces `drv1_en_o` = 0 in either mode, overriding `reg_swing1_i`.
- R11: While `rst_ni` is low, the threshold register is clear, so `sd_n_o` equals the inverse of `sig_det_i` whatever the cable length is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_mode_i | input | 1 | 0 = hardware pins, 1 = register fields |
| hw_bypass_i | input | 2 | Three-level bypass pin: 00 low, 01 floating, 1x high |
| hw_autosleep_i | input | 1 | Hardware auto power-down request |
| hw_mute_i | input | 1 | Hardware mute request |
| hw_drv1_off_i | input | 1 | Second driver disable pin, overrides the register |
| sig_det_i | input | 1 | Input signal detected |
| cli_i | input | 9 | Cable-length index |
| rate_i | input | 2 | Detected rate: 00 SD, 01 HD, 10 3G, 11 undetermined |
| reg_sleep_i | input | 2 | Software sleep field |
| reg_mute_i | input | 1 | Software mute |
| reg_eq_byp_i | input | 1 | Software equalizer bypass |
| reg_jc_byp_i | input | 1 | Software jitter-cleaner bypass |
| reg_dmute_en_i | input | 1 | Enable for the digital length-threshold mute |
| reg_dmute_code_i | input | 5 | Length-threshold code |
| reg_swing0_i | input | 2 | Swing code of driver 0, 00 = off |
| reg_swing1_i | input | 2 | Swing code of driver 1, 00 = off |
| eq_en_o | output | 1 | Equalizer powered |
| eq_bypass_o | output | 1 | Equalizer bypassed |
| jc_en_o | output | 1 | Jitter cleaner active |
| mute_o | output | 1 | Outputs forced to zero |
| drv0_en_o | output | 1 | Driver 0 enabled |
| drv1_en_o | output | 1 | Driver 1 enabled |
| sd_n_o | output | 1 | Signal-detect complement |

## Verification
Threshold codes are driven both on listed and unlisted values, with the cable-length index exactly at the limit and one above it. A wrong rounding direction, or a comparison that is not strict, would then mute one step early or late. The bench stacks sleep, mute and bypass requests together. A precedence chain in the wrong order would show a bypass or mute flag while the block is asleep. It also checks that the threshold register clears as soon as the signal is lost, and that the threshold mute arrives one cycle after the cable becomes too long; a design that is combinational or two cycles late fails here. Reserved rate and sleep codes are covered too, and the bench checks that the pins of the inactive mode leave the outputs unchanged.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam int CLI_W  = 9;
  localparam int CODE_W = 5;
  localparam int LIM_W  = CLI_W + 1;

  typedef enum logic [1:0] {
    SLP_ON   = 2'b00,
    SLP_AUTO = 2'b01,
    SLP_OFF  = 2'b10,
    SLP_RSVD = 2'b11
  } sleep_e;

  typedef enum logic [1:0] {
    RATE_SD  = 2'b00,
    RATE_HD  = 2'b01,
    RATE_3G  = 2'b10,
    RATE_UNK = 2'b11
  } rate_e;

  typedef struct packed {
    logic sleep;
    logic mute;
    logic eq_byp;
    logic jc_byp;
  } ctrl_req_t;

  // CLI limit for a threshold code; unlisted codes round up; 31 never trips
  function automatic logic [LIM_W-1:0] mute_limit(input logic [CODE_W-1:0] code);
    logic [LIM_W-1:0] lim;
    if      (code <= 5'd0)  lim = 10'd16;
    else if (code <= 5'd2)  lim = 10'd40;
    else if (code <= 5'd5)  lim = 10'd80;
    else if (code <= 5'd7)  lim = 10'd120;
    else if (code <= 5'd10) lim = 10'd160;
    else if (code <= 5'd12) lim = 10'd200;
    else if (code <= 5'd15) lim = 10'd240;
    else if (code <= 5'd17) lim = 10'd280;
    else if (code <= 5'd20) lim = 10'd320;
    else if (code <= 5'd25) lim = 10'd400;
    else if (code == 5'd26) lim = 10'd420;
    else if (code == 5'd27) lim = 10'd440;
    else if (code == 5'd28) lim = 10'd460;
    else if (code <= 5'd30) lim = 10'd480;
    else                    lim = 10'd512;
    return lim;
  endfunction
endpackage

// File: rtl/eqc_thresh.sv
module eqc_thresh
  import eqc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sig_det_i,
  input  logic [CLI_W-1:0] cli_i,
  input  logic [CODE_W-1:0] code_i,
  output logic             over_o
);
  logic [LIM_W-1:0] lim;
  logic             over_q;

  assign lim = mute_limit(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) over_q <= 1'b0;
    else         over_q <= en_i && sig_det_i && ({1'b0, cli_i} > lim);
  end

  assign over_o = over_q;

  // R8
  over_clear_on_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_det_i |=> !over_q);
  // R8
  over_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !over_q);
endmodule

// File: rtl/eqc_src_sel.sv
module eqc_src_sel
  import eqc_pkg::*;
(
  input  logic       sw_mode_i,
  input  logic [1:0] hw_bypass_i,
  input  logic       hw_autosleep_i,
  input  logic       hw_mute_i,
  input  logic       hw_drv1_off_i,
  input  logic       sig_det_i,
  input  logic [1:0] reg_sleep_i,
  input  logic       reg_mute_i,
  input  logic       reg_eq_byp_i,
  input  logic       reg_jc_byp_i,
  input  logic       thr_over_i,
  input  logic [1:0] reg_swing0_i,
  input  logic [1:0] reg_swing1_i,
  output ctrl_req_t  req_o,
  output logic       drv0_req_o,
  output logic       drv1_req_o
);
  sleep_e sleep_mode;
  logic   hw_high, hw_float;

  assign hw_high  = hw_bypass_i[1];
  assign hw_float = (hw_bypass_i == 2'b01);

  always_comb begin
    if (sw_mode_i) sleep_mode = sleep_e'(reg_sleep_i);
    else           sleep_mode = hw_autosleep_i ? SLP_AUTO : SLP_ON;
  end

  always_comb begin
    req_o.sleep = (sleep_mode == SLP_OFF) || ((sleep_mode == SLP_AUTO) && !sig_det_i);
    if (sw_mode_i) begin
      req_o.mute   = reg_mute_i || thr_over_i;
      req_o.eq_byp = reg_eq_byp_i;
      req_o.jc_byp = reg_jc_byp_i;
      drv0_req_o   = (reg_swing0_i != 2'b00);
      drv1_req_o   = (reg_swing1_i != 2'b00) && !hw_drv1_off_i;
    end else begin
      req_o.mute   = hw_mute_i;
      req_o.eq_byp = hw_high;
      req_o.jc_byp = hw_high || hw_float;
      drv0_req_o   = 1'b1;
      drv1_req_o   = !hw_drv1_off_i;
    end
  end
endmodule

// File: rtl/eqc_resolve.sv
module eqc_resolve
  import eqc_pkg::*;
(
  input  ctrl_req_t  req_i,
  input  logic [1:0] rate_i,
  input  logic       drv0_req_i,
  input  logic       drv1_req_i,
  output logic       eq_en_o,
  output logic       eq_bypass_o,
  output logic       jc_en_o,
  output logic       mute_o,
  output logic       drv0_en_o,
  output logic       drv1_en_o
);
  logic rate_ok, awake, live;

  assign rate_ok = (rate_e'(rate_i) == RATE_HD) || (rate_e'(rate_i) == RATE_3G);
  assign awake   = !req_i.sleep;
  assign live    = awake && !req_i.mute;

  assign eq_en_o     = awake;
  assign mute_o      = awake && req_i.mute;
  assign eq_bypass_o = live && req_i.eq_byp;
  assign jc_en_o     = live && !req_i.jc_byp && rate_ok;
  assign drv0_en_o   = awake && drv0_req_i;
  assign drv1_en_o   = awake && drv1_req_i;
endmodule

// File: rtl/eq_mode_mute_ctrl.sv
module eq_mode_mute_ctrl
  import eqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_mode_i,
  input  logic [1:0]        hw_bypass_i,
  input  logic              hw_autosleep_i,
  input  logic              hw_mute_i,
  input  logic              hw_drv1_off_i,
  input  logic              sig_det_i,
  input  logic [CLI_W-1:0]  cli_i,
  input  logic [1:0]        rate_i,
  input  logic [1:0]        reg_sleep_i,
  input  logic              reg_mute_i,
  input  logic              reg_eq_byp_i,
  input  logic              reg_jc_byp_i,
  input  logic              reg_dmute_en_i,
  input  logic [CODE_W-1:0] reg_dmute_code_i,
  input  logic [1:0]        reg_swing0_i,
  input  logic [1:0]        reg_swing1_i,
  output logic              eq_en_o,
  output logic              eq_bypass_o,
  output logic              jc_en_o,
  output logic              mute_o,
  output logic              drv0_en_o,
  output logic              drv1_en_o,
  output logic              sd_n_o
);
  ctrl_req_t req;
  logic      thr_over, drv0_req, drv1_req;

  eqc_thresh u_thresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sw_mode_i && reg_dmute_en_i),
    .sig_det_i (sig_det_i),
    .cli_i     (cli_i),
    .code_i    (reg_dmute_code_i),
    .over_o    (thr_over)
  );

  eqc_src_sel u_src (
    .sw_mode_i      (sw_mode_i),
    .hw_bypass_i    (hw_bypass_i),
    .hw_autosleep_i (hw_autosleep_i),
    .hw_mute_i      (hw_mute_i),
    .hw_drv1_off_i  (hw_drv1_off_i),
    .sig_det_i      (sig_det_i),
    .reg_sleep_i    (reg_sleep_i),
    .reg_mute_i     (reg_mute_i),
    .reg_eq_byp_i   (reg_eq_byp_i),
    .reg_jc_byp_i   (reg_jc_byp_i),
    .thr_over_i     (thr_over),
    .reg_swing0_i   (reg_swing0_i),
    .reg_swing1_i   (reg_swing1_i),
    .req_o          (req),
    .drv0_req_o     (drv0_req),
    .drv1_req_o     (drv1_req)
  );

  eqc_resolve u_res (
    .req_i       (req),
    .rate_i      (rate_i),
    .drv0_req_i  (drv0_req),
    .drv1_req_i  (drv1_req),
    .eq_en_o     (eq_en_o),
    .eq_bypass_o (eq_bypass_o),
    .jc_en_o     (jc_en_o),
    .mute_o      (mute_o),
    .drv0_en_o   (drv0_en_o),
    .drv1_en_o   (drv1_en_o)
  );

  assign sd_n_o = !sig_det_i || thr_over;

  // R5
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eq_en_o |-> !(mute_o || eq_bypass_o || jc_en_o || drv0_en_o || drv1_en_o));
  // R5
  mute_over_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> (!eq_bypass_o && !jc_en_o && eq_en_o));
  // R9
  jc_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jc_en_o |-> (rate_i == 2'b01 || rate_i == 2'b10));
  // R10
  drv1_pin_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_drv1_off_i |-> !drv1_en_o);
  // R6
  sd_n_no_signal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_det_i |-> sd_n_o);
  // R8
  hw_no_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_mode_i && sig_det_i) |=> (!sw_mode_i && sig_det_i) |-> !sd_n_o);
endmodule

// File: tb/eq_mode_mute_ctrl_tb.sv
module eq_mode_mute_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_mode = 0, hw_auto = 0, hw_mute = 0, hw_d1off = 0, sig_det = 0;
  logic [1:0] hw_byp = 0, rate = 0, r_sleep = 0, r_sw0 = 0, r_sw1 = 0;
  logic r_mute = 0, r_eqb = 0, r_jcb = 0, r_den = 0;
  logic [4:0] r_code = 0;
  logic [8:0] cli = 0;
  logic eq_en, eq_byp, jc_en, mute, d0, d1, sd_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit m_over = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eq_mode_mute_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_mode_i(sw_mode), .hw_bypass_i(hw_byp),
    .hw_autosleep_i(hw_auto), .hw_mute_i(hw_mute), .hw_drv1_off_i(hw_d1off),
    .sig_det_i(sig_det), .cli_i(cli), .rate_i(rate), .reg_sleep_i(r_sleep),
    .reg_mute_i(r_mute), .reg_eq_byp_i(r_eqb), .reg_jc_byp_i(r_jcb),
    .reg_dmute_en_i(r_den), .reg_dmute_code_i(r_code), .reg_swing0_i(r_sw0),
    .reg_swing1_i(r_sw1), .eq_en_o(eq_en), .eq_bypass_o(eq_byp), .jc_en_o(jc_en),
    .mute_o(mute), .drv0_en_o(d0), .drv1_en_o(d1), .sd_n_o(sd_n)
  );

  // listed metre limits; 0 = unlisted, -1 = never
  function automatic int listed_m(int c);
    case (c)
      0: return 10;   2: return 25;   5: return 50;   7: return 75;
      10: return 100; 12: return 125; 15: return 150; 17: return 175;
      20: return 200; 25: return 250; 26: return 300; 27: return 350;
      28: return 400; 30: return 450; 31: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int cli_limit(int code);
    int m = 0;
    for (int c = code; c < 32; c++) begin
      m = listed_m(c);
      if (m != 0) break;
    end
    if (m < 0) return 100000;
    if (m <= 250) return (m * 8) / 5;
    return 400 + ((m - 250) * 2) / 5;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_over <= 0;
    else m_over <= sw_mode && r_den && sig_det && (int'(cli) > cli_limit(int'(r_code)));
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model compared every cycle
  always @(negedge clk) begin
    bit slp, mu, eb, jb, awake, live, rok, w0, w1;
    int smode;
    if (!done) begin
      smode = sw_mode ? int'(r_sleep) : (hw_auto ? 1 : 0);
      slp = (smode == 2) || (smode == 1 && !sig_det);
      mu  = sw_mode ? (r_mute || m_over) : hw_mute;
      eb  = sw_mode ? r_eqb : (hw_byp >= 2);
      jb  = sw_mode ? r_jcb : (hw_byp != 0);
      w0  = sw_mode ? (r_sw0 != 0) : 1;
      w1  = (sw_mode ? (r_sw1 != 0) : 1) && !hw_d1off;
      rok = (rate == 1) || (rate == 2);
      awake = !slp;
      live = awake && !mu;
      chk("R4 eq_en", eq_en, awake);
      chk("R5 mute", mute, awake && mu);
      chk("R2 eq_bypass", eq_byp, live && eb);
      chk("R9 jc_en", jc_en, live && !jb && rok);
      chk("R10 drv0", d0, awake && w0);
      chk("R10 drv1", d1, awake && w1);
      chk("R6 sd_n", sd_n, !sig_det || m_over);
    end
  end

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic at_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset holds threshold clear
    sw_mode = 1; r_den = 1; r_code = 0; cli = 9'd500; sig_det = 1; r_sw0 = 1; r_sw1 = 1;
    repeat (3) @(negedge clk);
    chk("R11 sd_n in reset", sd_n, 1'b0);
    chk("R11 mute in reset", mute, 1'b0);
    at_edge(); rst_n = 1;

    // hardware mode bypass levels (R2), rate HD
    at_edge(); sw_mode = 0; r_den = 0; rate = 2'b01; hw_byp = 2'b00;
    settle(); chk("R2 low jc", jc_en, 1); chk("R2 low eqbyp", eq_byp, 0);
    at_edge(); hw_byp = 2'b01;
    settle(); chk("R2 float jc", jc_en, 0); chk("R2 float eqbyp", eq_byp, 0);
    at_edge(); hw_byp = 2'b10;
    settle(); chk("R2 high jc", jc_en, 0); chk("R2 high eqbyp", eq_byp, 1);
    // R5 mute over bypass
    at_edge(); hw_mute = 1;
    settle(); chk("R5 mute wins", mute, 1); chk("R5 no bypass", eq_byp, 0);
    // R3 autosleep
    at_edge(); hw_auto = 1; sig_det = 0;
    settle(); chk("R3 asleep", eq_en, 0); chk("R5 sleep beats mute", mute, 0);
    at_edge(); sig_det = 1;
    settle(); chk("R3 awake", eq_en, 1);
    // R1: register fields ignored in hardware mode
    at_edge(); hw_mute = 0; hw_byp = 0; r_sleep = 2'b10; r_mute = 1; r_sw0 = 0;
    settle(); chk("R1 hw ignores reg sleep", eq_en, 1); chk("R1 hw ignores reg mute", mute, 0);
    chk("R1 hw drv0 on", d0, 1);
    // R1: pins ignored in software mode
    at_edge(); sw_mode = 1; r_sleep = 0; r_mute = 0; r_sw0 = 2'b10; hw_mute = 1; hw_byp = 2'b10;
    settle(); chk("R1 sw ignores pin mute", mute, 0); chk("R1 sw ignores pin bypass", eq_byp, 0);
    // R4 sleep codes
    at_edge(); hw_mute = 0; hw_byp = 0; r_sleep = 2'b01; sig_det = 0;
    settle(); chk("R4 auto no sig", eq_en, 0);
    at_edge(); r_sleep = 2'b11;
    settle(); chk("R4 reserved on", eq_en, 1);
    at_edge(); r_sleep = 2'b10; sig_det = 1;
    settle(); chk("R4 forced off", eq_en, 0);
    at_edge(); r_sleep = 2'b00;
    // R9 rate codes
    at_edge(); rate = 2'b11; settle(); chk("R9 unknown rate", jc_en, 0);
    at_edge(); rate = 2'b00; settle(); chk("R9 SD rate", jc_en, 0);
    at_edge(); rate = 2'b10; r_jcb = 1; settle(); chk("R9 jc bypass bit", jc_en, 0);
    at_edge(); r_jcb = 0; settle(); chk("R9 3G on", jc_en, 1);
    // R10 driver override and swing 00
    at_edge(); r_sw1 = 2'b11; hw_d1off = 1; settle(); chk("R10 pin overrides", d1, 0);
    at_edge(); hw_d1off = 0; r_sw1 = 0; settle(); chk("R10 swing 00 off", d1, 0);
    // R7/R8 thresholds
    at_edge(); r_den = 1; r_code = 5'd20; cli = 9'd320;
    settle(); chk("R7 at limit", mute, 0);
    at_edge(); cli = 9'd321;
    @(negedge clk); chk("R8 not yet", sd_n, 0);
    @(negedge clk); chk("R8 one cycle later", sd_n, 1); chk("R8 muted", mute, 1);
    at_edge(); r_code = 5'd1; cli = 9'd40;
    settle(); chk("R7 unlisted rounds up", mute, 0);
    at_edge(); cli = 9'd41; settle(); chk("R7 unlisted over", mute, 1);
    at_edge(); sig_det = 0; settle(); chk("R8 cleared on loss", mute, 0);
    at_edge(); sig_det = 1; r_code = 5'd31; cli = 9'd511;
    settle(); chk("R7 never mute", mute, 0);
    at_edge(); r_code = 5'd26; cli = 9'd421; settle(); chk("R7 300m over", sd_n, 1);
    at_edge(); r_den = 0; settle(); chk("R8 disabled", sd_n, 0);

    // random sweep against the model
    for (int i = 0; i < 3000; i++) begin
      at_edge();
      sw_mode = $urandom_range(0, 3) != 0;
      hw_byp = 2'($urandom); hw_auto = 1'($urandom); hw_mute = ($urandom_range(0, 3) == 0);
      hw_d1off = 1'($urandom); sig_det = ($urandom_range(0, 5) != 0);
      rate = 2'($urandom); r_sleep = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      r_mute = ($urandom_range(0, 5) == 0); r_eqb = 1'($urandom); r_jcb = 1'($urandom);
      r_den = 1'($urandom); r_code = 5'($urandom);
      if ($urandom_range(0, 1) == 0) cli = 9'($urandom);
      else cli = 9'(cli_limit(int'(r_code)) + $urandom_range(0, 2) - 1);
      r_sw0 = 2'($urandom); r_sw1 = 2'($urandom);
    end
    settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule